// File: doc/BRIEF.md
# Multiplexed Bus Front End with Byte RAM

This block sits on an 8-bit bus that carries the address first and the data afterwards. It recognises each access and sends it either to a RAM inside the block or to a small set of I/O registers. When the address-latch enable falls, three things are captured together: the address on the bus, the space select (I/O or memory) and the active-low chip select. Every later read or write strobe uses these latched values, not the live pins.

In memory space the whole latched byte addresses a 256-byte RAM array held inside the block. In I/O space only the low three address bits are decoded, giving six register slots:

| Slot | Read | Write |
|------|------|-------|
| 0 | status | command |
| 1 | port A | port A |
| 2 | port B | port B |
| 3 | port C | port C |
| 4 | timer low byte | timer low byte |
| 5 | timer high byte | timer high byte |

The command register lives in this block. All other register contents are supplied by neighbouring port and timer blocks. The front end tells those blocks about accesses through single-cycle read and write pulses, a slot number and the write data. A read of slot 0 also produces a status-read pulse, which the timer block uses to clear its flag.

The bus is driven in three-state form: a data output plus an output enable. All strobes are sampled on `clk_i`.

Top module: `mbus_front_end`

## Requirements
- R1: Address, space select and chip select are captured at the clock edge that first samples `ale_i` low after it was high. Changes on those pins after the capture have no effect on the access.
- R2: When the captured chip select is 1, reads leave `ad_oe_o` at 0, writes change neither the RAM nor any register, and no pulses are issued.
- R3: A captured space select of 1 routes the access to the I/O slots. A value of 0 routes it to the RAM byte at the captured address.
- R4: In I/O space only address bits 2:0 choose the slot, and bits 7:3 are ignored. Slot 0 writes the command register and reads the status word (`io_rdata_i[7:0]`). Slot k in 1..5 reads `io_rdata_i[8k+7:8k]`, and a write to it is reported with `reg_sel_o` = k.
- R5: While `rd_ni` is 0, `wr_ni` is 1 and the chip is selected, `ad_oe_o` is 1 and `ad_o` carries the selected byte. Otherwise `ad_oe_o` is 0 and `ad_o` is 0.
- R6: A write stores the bus byte into the selected RAM byte, or into the selected I/O slot.
- R7: `rst_ni` low clears the command register asynchronously, to 0.
- R8: A write takes effect at the first clock edge that samples `wr_ni` high after it was low. The byte used is the last one sampled on `ad_i` while `wr_ni` was low.
- R9: Each write to slots 0..5 raises `wr_pulse_o` for exactly one cycle, in the cycle after the strobe's rising edge is sampled. `reg_sel_o` and `wr_data_o` are valid in that same cycle.
- R10: A read of slot 0 raises both `status_rd_o` and `rd_pulse_o` for one cycle, in the cycle after the falling read strobe is sampled. Reads of slots 1..5 raise only `rd_pulse_o`.
- R11: Slots 6 and 7 read as 0 and ignore writes. They produce no pulses and leave the command register unchanged.
- R12: If `rd_ni` and `wr_ni` are both sampled low during a write access, or `rd_ni` is low when the write strobe rises, that write takes no effect and issues no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch enable; capture on its fall |
| cs_ni | input | 1 | Active-low chip select, latched |
| io_sel_i | input | 1 | 1 = I/O space, 0 = memory, latched |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| ad_i | input | 8 | Bus input: address, then data |
| ad_o | output | 8 | Bus read data |
| ad_oe_o | output | 1 | Bus output enable |
| io_rdata_i | input | 48 | Read bytes for slots 0..5, slot k at bits 8k+7:8k |
| cmd_o | output | 8 | Command register contents |
| reg_sel_o | output | 3 | Slot number of the current pulse |
| wr_pulse_o | output | 1 | One-cycle I/O write pulse |
| rd_pulse_o | output | 1 | One-cycle I/O read pulse |
| status_rd_o | output | 1 | One-cycle pulse when slot 0 is read |
| wr_data_o | output | 8 | Data of the I/O write |

## Verification
The assertions check these properties on every cycle:
- a write pulse is one cycle long and follows a sampled rise of the write strobe;
- no write pulse follows a cycle in which the read strobe was low;
- the status pulse always coincides with a read pulse for slot 0;
- the command register changes only together with a slot-0 write pulse;
- the bus is enabled only when a read is under way and the chip is selected.

Other behaviours can only be shown by the bench's scenarios, because they need data that outlives a single access:
- that RAM and I/O space are kept apart;
- that the latched select, not the live pin, governs the access;
- that blocked writes leave RAM contents unchanged;
- that slots 6 and 7 read zero;
- that reset clears the command register.

// File: rtl/mbus_fe_pkg.sv
package mbus_fe_pkg;
  localparam int unsigned MBUS_W     = 8;
  localparam int unsigned MBUS_REGS  = 6;
  localparam int unsigned MBUS_IDX_W = 3;

  typedef struct packed {
    logic io;
    logic dis;
  } acc_space_t;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
  import mbus_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = MBUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_sel_i,
  input  logic              cs_ni,
  output logic [ADDR_W-1:0] addr_o,
  output acc_space_t        space_o
);
  logic ale_q;
  logic ale_fall;

  assign ale_fall = ale_q & ~ale_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q   <= 1'b0;
      addr_o  <= '0;
      space_o <= '{io: 1'b0, dis: 1'b1};
    end else begin
      ale_q <= ale_i;
      if (ale_fall) begin
        addr_o  <= addr_i;
        space_o <= '{io: io_sel_i, dis: cs_ni};
      end
    end
  end
endmodule

// File: rtl/mbus_strobe_ctrl.sv
module mbus_strobe_ctrl
  import mbus_fe_pkg::*;
#(
  parameter int unsigned DATA_W = MBUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              dis_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_act_o,
  output logic              rd_start_o,
  output logic              wr_commit_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic rd_q, wr_q, err_q;
  logic both_low;

  assign both_low    = ~rd_ni & ~wr_ni;
  assign rd_act_o    = ~rd_ni & wr_ni & ~dis_i;
  assign rd_start_o  = rd_act_o & ~rd_q;
  // rising write strobe, no overlap seen during or at the end of the access
  assign wr_commit_o = wr_q & wr_ni & rd_ni & ~err_q & ~dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      wdata_o <= '0;
    end else begin
      rd_q <= rd_act_o;
      wr_q <= ~wr_ni;
      if (both_low)          err_q <= 1'b1;
      else if (rd_ni && wr_ni) err_q <= 1'b0;
      if (!wr_ni) wdata_o <= data_i;
    end
  end
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram
  import mbus_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = MBUS_W,
  parameter int unsigned DATA_W = MBUS_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mbus_front_end.sv
module mbus_front_end
  import mbus_fe_pkg::*;
#(
  parameter int unsigned BUS_W  = MBUS_W,
  parameter int unsigned NUM_IO = MBUS_REGS,
  parameter int unsigned IDX_W  = MBUS_IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ale_i,
  input  logic                    cs_ni,
  input  logic                    io_sel_i,
  input  logic                    rd_ni,
  input  logic                    wr_ni,
  input  logic [BUS_W-1:0]        ad_i,
  output logic [BUS_W-1:0]        ad_o,
  output logic                    ad_oe_o,
  input  logic [NUM_IO*BUS_W-1:0] io_rdata_i,
  output logic [BUS_W-1:0]        cmd_o,
  output logic [IDX_W-1:0]        reg_sel_o,
  output logic                    wr_pulse_o,
  output logic                    rd_pulse_o,
  output logic                    status_rd_o,
  output logic [BUS_W-1:0]        wr_data_o
);
  localparam logic [IDX_W-1:0] CMD_IDX = '0;

  logic [BUS_W-1:0] addr_lat;
  acc_space_t       space_lat;
  logic             dis_lat;
  logic             rd_act, rd_start, wr_commit;
  logic [BUS_W-1:0] wdata;
  logic [BUS_W-1:0] ram_rdata;
  logic [BUS_W-1:0] io_word;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic             ram_we, io_we, io_rd;

  mbus_addr_latch #(.ADDR_W(BUS_W)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ale_i    (ale_i),
    .addr_i   (ad_i),
    .io_sel_i (io_sel_i),
    .cs_ni    (cs_ni),
    .addr_o   (addr_lat),
    .space_o  (space_lat)
  );

  assign dis_lat = space_lat.dis;

  mbus_strobe_ctrl #(.DATA_W(BUS_W)) u_stb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_ni       (rd_ni),
    .wr_ni       (wr_ni),
    .dis_i       (dis_lat),
    .data_i      (ad_i),
    .rd_act_o    (rd_act),
    .rd_start_o  (rd_start),
    .wr_commit_o (wr_commit),
    .wdata_o     (wdata)
  );

  assign idx    = addr_lat[IDX_W-1:0];
  assign idx_ok = 32'(idx) < NUM_IO;
  assign ram_we = wr_commit & ~space_lat.io;
  assign io_we  = wr_commit & space_lat.io & idx_ok;
  assign io_rd  = rd_start & space_lat.io & idx_ok;

  mbus_ram #(.ADDR_W(BUS_W), .DATA_W(BUS_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (addr_lat),
    .wdata_i (wdata),
    .raddr_i (addr_lat),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    io_word = '0;
    for (int unsigned k = 0; k < NUM_IO; k++) begin
      if (idx == IDX_W'(k)) io_word = io_rdata_i[k*BUS_W +: BUS_W];
    end
  end

  assign ad_oe_o = rd_act;
  assign ad_o    = !rd_act ? '0 : (space_lat.io ? io_word : ram_rdata);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= '0;
      reg_sel_o   <= '0;
      wr_pulse_o  <= 1'b0;
      rd_pulse_o  <= 1'b0;
      status_rd_o <= 1'b0;
      wr_data_o   <= '0;
    end else begin
      wr_pulse_o  <= io_we;
      rd_pulse_o  <= io_rd;
      status_rd_o <= io_rd && idx == CMD_IDX;
      if (io_we || io_rd) reg_sel_o <= idx;
      if (io_we) wr_data_o <= wdata;
      if (io_we && idx == CMD_IDX) cmd_o <= wdata;
    end
  end
endmodule

// File: rtl/mbus_front_end_chk.sv
module mbus_front_end_chk #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NUM_IO = 6,
  parameter int unsigned IDX_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_ni,
  input logic             wr_ni,
  input logic             ad_oe_o,
  input logic             dis_lat,
  input logic [BUS_W-1:0] cmd_o,
  input logic [IDX_W-1:0] reg_sel_o,
  input logic             wr_pulse_o,
  input logic             rd_pulse_o,
  input logic             status_rd_o,
  input logic [BUS_W-1:0] wr_data_o
);
  // R9
  wr_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o);

  // R8
  wr_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |-> ($past(wr_ni) && !$past(wr_ni, 2)));

  // R12
  no_wr_with_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |-> $past(rd_ni));

  // R10
  status_is_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_o |-> (rd_pulse_o && reg_sel_o == '0));

  // R4
  cmd_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> (wr_pulse_o && reg_sel_o == '0 && cmd_o == wr_data_o));

  // R11
  sel_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse_o || rd_pulse_o) |-> (32'(reg_sel_o) < NUM_IO));

  // R2
  no_drive_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (!dis_lat && !rd_ni));
endmodule

bind mbus_front_end mbus_front_end_chk #(.BUS_W(BUS_W), .NUM_IO(NUM_IO), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_ni       (rd_ni),
  .wr_ni       (wr_ni),
  .ad_oe_o     (ad_oe_o),
  .dis_lat     (dis_lat),
  .cmd_o       (cmd_o),
  .reg_sel_o   (reg_sel_o),
  .wr_pulse_o  (wr_pulse_o),
  .rd_pulse_o  (rd_pulse_o),
  .status_rd_o (status_rd_o),
  .wr_data_o   (wr_data_o)
);

// File: tb/test_mbus_front_end.sv
module test_mbus_front_end;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ale = 1'b0, cs_n = 1'b1, io_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  ad_i = 8'h00;
  logic [7:0]  ad_o, cmd_o, wr_data_o;
  logic        ad_oe_o, wr_pulse_o, rd_pulse_o, status_rd_o;
  logic [2:0]  reg_sel_o;
  logic [47:0] io_rdata = {8'h65, 8'h54, 8'h43, 8'h32, 8'h21, 8'hA5};

  int n_vec = 0, n_bad = 0;
  int wp_cnt = 0, rp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbus_front_end i_mbus_front_end (
    .clk_i(clk), .rst_ni(rst_ni), .ale_i(ale), .cs_ni(cs_n), .io_sel_i(io_sel),
    .rd_ni(rd_n), .wr_ni(wr_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .io_rdata_i(io_rdata), .cmd_o(cmd_o), .reg_sel_o(reg_sel_o),
    .wr_pulse_o(wr_pulse_o), .rd_pulse_o(rd_pulse_o), .status_rd_o(status_rd_o),
    .wr_data_o(wr_data_o)
  );

  always @(posedge clk) begin
    if (wr_pulse_o) wp_cnt++;
    if (rd_pulse_o) rp_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic latch(input logic io, input logic dis, input logic [7:0] a);
    @(negedge clk); ale = 1'b1; ad_i = a; io_sel = io; cs_n = dis;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); ad_i = ~a; io_sel = ~io; cs_n = ~dis;
  endtask

  task automatic bus_wr(input string req, input logic [7:0] d, input bit exp_p,
                        input logic [2:0] exp_sel);
    int base;
    @(negedge clk); ad_i = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_n = 1'b1; ad_i = d ^ 8'h3C; base = wp_cnt;
    @(negedge clk);
    chk({req, " pulse"}, 32'(wr_pulse_o), 32'(exp_p));
    if (exp_p) begin
      chk({req, " sel"}, 32'(reg_sel_o), 32'(exp_sel));
      chk({req, " data"}, 32'(wr_data_o), 32'(d));
    end
    @(negedge clk); @(negedge clk);
    chk({req, " pulse count"}, 32'(wp_cnt - base), 32'(exp_p));
  endtask

  task automatic bus_rd(input string req, input bit exp_oe, input logic [7:0] exp_d,
                        input bit exp_p, input bit exp_st);
    int base;
    @(negedge clk); rd_n = 1'b0; base = rp_cnt;
    #1;
    chk({req, " oe"}, 32'(ad_oe_o), 32'(exp_oe));
    chk({req, " data"}, 32'(ad_o), exp_oe ? 32'(exp_d) : 32'h0);
    @(negedge clk);
    chk({req, " rd pulse"}, 32'(rd_pulse_o), 32'(exp_p));
    chk({req, " status pulse"}, 32'(status_rd_o), 32'(exp_st));
    @(negedge clk); rd_n = 1'b1;
    #1 chk({req, " release"}, 32'(ad_oe_o), 32'h0);
    @(negedge clk); @(negedge clk);
    chk({req, " rd count"}, 32'(rp_cnt - base), 32'(exp_p));
  endtask

  task automatic t_reset;
    chk("R7 reset cmd", 32'(cmd_o), 32'h0);
    chk("R5 reset oe", 32'(ad_oe_o), 32'h0);
    chk("R9 reset pulses", {29'h0, wr_pulse_o, rd_pulse_o, status_rd_o}, 32'h0);
  endtask

  task automatic t_ram;
    latch(1'b0, 1'b0, 8'h00); bus_wr("R6 ram wr 00", 8'hC3, 1'b0, 3'd0);
    latch(1'b0, 1'b0, 8'hFF); bus_wr("R6 ram wr FF", 8'h5A, 1'b0, 3'd0);
    latch(1'b0, 1'b0, 8'h01); bus_wr("R3 ram wr 01", 8'h0F, 1'b0, 3'd0);
    latch(1'b0, 1'b0, 8'h00); bus_rd("R8 ram rd 00", 1'b1, 8'hC3, 1'b0, 1'b0);
    latch(1'b0, 1'b0, 8'hFF); bus_rd("R1 ram rd FF", 1'b1, 8'h5A, 1'b0, 1'b0);
  endtask

  task automatic t_io_wr;
    latch(1'b1, 1'b0, 8'h01); bus_wr("R9 io wr slot1", 8'h77, 1'b1, 3'd1);
    latch(1'b1, 1'b0, 8'hFB); bus_wr("R4 io wr upper bits", 8'h12, 1'b1, 3'd3);
    latch(1'b1, 1'b0, 8'h05); bus_wr("R9 io wr slot5", 8'hE1, 1'b1, 3'd5);
    latch(1'b1, 1'b0, 8'h00); bus_wr("R4 cmd wr", 8'h5C, 1'b1, 3'd0);
    chk("R4 cmd value", 32'(cmd_o), 32'h5C);
    latch(1'b0, 1'b0, 8'h01); bus_rd("R3 ram kept apart", 1'b1, 8'h0F, 1'b0, 1'b0);
  endtask

  task automatic t_io_rd;
    latch(1'b1, 1'b0, 8'h00); bus_rd("R10 status rd", 1'b1, 8'hA5, 1'b1, 1'b1);
    latch(1'b1, 1'b0, 8'h02); bus_rd("R4 rd slot2", 1'b1, 8'h32, 1'b1, 1'b0);
    latch(1'b1, 1'b0, 8'hC4); bus_rd("R4 rd slot4", 1'b1, 8'h54, 1'b1, 1'b0);
    latch(1'b1, 1'b0, 8'h05); bus_rd("R5 rd slot5", 1'b1, 8'h65, 1'b1, 1'b0);
  endtask

  task automatic t_unused;
    latch(1'b1, 1'b0, 8'h06); bus_rd("R11 rd slot6", 1'b1, 8'h00, 1'b0, 1'b0);
    latch(1'b1, 1'b0, 8'h07); bus_wr("R11 wr slot7", 8'hAA, 1'b0, 3'd0);
    chk("R11 cmd unchanged", 32'(cmd_o), 32'h5C);
  endtask

  task automatic t_disabled;
    latch(1'b0, 1'b0, 8'h30); bus_wr("R6 ram wr 30", 8'h44, 1'b0, 3'd0);
    latch(1'b0, 1'b1, 8'h30); bus_rd("R2 disabled rd", 1'b0, 8'h00, 1'b0, 1'b0);
    bus_wr("R2 disabled ram wr", 8'hEE, 1'b0, 3'd0);
    latch(1'b1, 1'b1, 8'h00); bus_wr("R2 disabled cmd wr", 8'h99, 1'b0, 3'd0);
    chk("R2 cmd unchanged", 32'(cmd_o), 32'h5C);
    latch(1'b0, 1'b0, 8'h30); bus_rd("R2 ram intact", 1'b1, 8'h44, 1'b0, 1'b0);
  endtask

  task automatic t_overlap;
    int base;
    latch(1'b0, 1'b0, 8'h20); bus_wr("R6 ram wr 20", 8'h11, 1'b0, 3'd0);
    @(negedge clk); rd_n = 1'b0; wr_n = 1'b0; ad_i = 8'h99;
    @(negedge clk); @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    latch(1'b0, 1'b0, 8'h20); bus_rd("R12 ram not written", 1'b1, 8'h11, 1'b0, 1'b0);
    latch(1'b1, 1'b0, 8'h00);
    base = wp_cnt;
    @(negedge clk); wr_n = 1'b0; ad_i = 8'h3F;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R12 no io pulse", 32'(wp_cnt - base), 32'h0);
    chk("R12 cmd unchanged", 32'(cmd_o), 32'h5C);
  endtask

  task automatic t_async_reset;
    @(negedge clk); rst_ni = 1'b0;
    #1 chk("R7 async clear", 32'(cmd_o), 32'h0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_ram();
    t_io_wr();
    t_io_rd();
    t_unused();
    t_disabled();
    t_overlap();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule